// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers level-sensitive interrupt requests from forty primary lines and thirty-two secondary lines and presents one interrupt output to a processor. The secondary lines have their own latch, mask and acknowledge registers. After masking, they are ORed together and fed into primary line 0. A processor therefore sees the whole secondary group as a single primary source. It acknowledges that source and then reads the secondary status to find which secondary line fired.

Software works through a 32-bit word-addressed register port. Primary registers come in two banks, with bank 1 carrying sources 32 to 39 in its low eight bits. Each bank has a write-one-to-clear pending register and a pair of enable registers: one sets enables when a 1 is written, the other clears them. A priority register reports the number of the lowest active primary channel, translated through a per-channel mapping table. The table resets to the identity mapping.

Top module: `intc_cascade`

## Requirements
- R1: After a synchronous active-high reset, every primary and secondary enable and pending bit is 0, `cpuIrq` is low, the priority register reads 0, and the mapping entry of each channel reads back its own channel number.
- R2: A primary pending bit is set on every clock edge at which its request input is high, and it stays set after the input drops. Reading 0x010 returns pending bits for sources 0 to 31; reading 0x014 returns sources 32 to 39 in bits 7:0.
- R3: Writing 0x010 or 0x014 clears the pending bits at the positions written as 1, and bits written as 0 are unchanged. If the request is high in the same cycle as the clear, the pending bit stays set.
- R4: A write of 1 to a bit of 0x020/0x024 enables that source, and a write of 1 to 0x030/0x034 disables it. Zero bits have no effect, and reads of 0x020/0x024 return the enable state, with only bits 7:0 of bank 1 implemented.
- R5: `cpuIrq` is high exactly when at least one primary source is both pending and enabled. It rises in the cycle after the edge that latched the request.
- R6: Reading 0x040 returns, in bits 5:0, the mapping entry of the lowest-numbered channel that is pending and enabled. All other bits are 0, and the value is 0 when no channel is active.
- R7: A secondary pending bit is set by its request input and is cleared by writing 1 to 0x088 (set wins over clear). Secondary enables are set by writing 1 to 0x090 and cleared by writing 1 to 0x098.
- R8: Reading 0x080 returns the secondary pending bits ANDed with the secondary enables.
- R9: While any secondary source is both pending and enabled, primary pending bit 0 is set on the next edge. Pending but disabled secondary sources do not set it.
- R10: Mapping entry c is at 0x200 + 4·c, holds 6 bits that are writable and readable, and its value is the one the priority register reports when channel c wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst | input | 1 | Synchronous active-high reset |
| regAddr | input | 12 | Byte address of the register access |
| regWe | input | 1 | Write strobe for the addressed register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational from state |
| primReq | input | 39 | Level requests for primary sources 1 to 39 (bit i-1 is source i) |
| secReq | input | 32 | Level requests for secondary sources 0 to 31 |
| cpuIrq | output | 1 | Interrupt request to the processor |

## Verification
The assertions check these properties on every cycle:
- a raised primary or secondary request is latched on the next edge;
- an enabled and pending secondary source drives primary line 0 pending;
- neither enable set changes without a register write;
- the processor request cannot drop without a write;
- the priority register reads 0 whenever the interrupt output is low.

Only the bench's scenarios can show the rest, because each depends on an ordered sequence of writes and requests:
- which channel wins and how its mapping entry is reported;
- that set wins over clear;
- that zero bits in set and clear writes are ignored;
- the 8-bit width of bank 1;
- the two-edge path from a secondary request to the output;
- that reset restores the identity mapping.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int PRIM_N     = 40;
  localparam int SEC_N      = 32;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 12;
  localparam int IDX_W      = 6;
  localparam int CHAN_W     = $clog2(PRIM_N);
  localparam int PRIM_BANKS = (PRIM_N + DATA_W - 1) / DATA_W;
  localparam int BANK_W     = (PRIM_BANKS > 1) ? $clog2(PRIM_BANKS) : 1;

  localparam int OFF_PCLR  = 'h010;
  localparam int OFF_ESET  = 'h020;
  localparam int OFF_ECLR  = 'h030;
  localparam int OFF_PIDX  = 'h040;
  localparam int OFF_SSTAT = 'h080;
  localparam int OFF_SCLR  = 'h088;
  localparam int OFF_SESET = 'h090;
  localparam int OFF_SECLR = 'h098;
  localparam int OFF_MAP   = 'h200;

  typedef enum logic [2:0] {
    RD_NONE, RD_PEND, RD_EN, RD_IDX, RD_SSTAT, RD_MAP
  } rdSel_e;

  typedef struct packed {
    logic [PRIM_BANKS-1:0] clrPend;
    logic [PRIM_BANKS-1:0] setEn;
    logic [PRIM_BANKS-1:0] clrEn;
    logic                  clrSec;
    logic                  setSecEn;
    logic                  clrSecEn;
    logic                  wrMap;
    logic [CHAN_W-1:0]     chan;
    rdSel_e                rdSel;
    logic [BANK_W-1:0]     bank;
  } strobe_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  output strobe_t           strb
);
  logic [ADDR_W-1:0] mapOff;

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    mapOff     = regAddr - ADDR_W'(OFF_MAP);

    for (int b = 0; b < PRIM_BANKS; b++) begin
      if (regAddr == ADDR_W'(OFF_PCLR + 4 * b)) begin
        strb.clrPend[b] = regWe;
        strb.rdSel      = RD_PEND;
        strb.bank       = BANK_W'(b);
      end
      if (regAddr == ADDR_W'(OFF_ESET + 4 * b)) begin
        strb.setEn[b] = regWe;
        strb.rdSel    = RD_EN;
        strb.bank     = BANK_W'(b);
      end
      if (regAddr == ADDR_W'(OFF_ECLR + 4 * b)) begin
        strb.clrEn[b] = regWe;
      end
    end

    if (regAddr == ADDR_W'(OFF_PIDX))  strb.rdSel = RD_IDX;
    if (regAddr == ADDR_W'(OFF_SSTAT)) strb.rdSel = RD_SSTAT;
    if (regAddr == ADDR_W'(OFF_SCLR))  strb.clrSec   = regWe;
    if (regAddr == ADDR_W'(OFF_SESET)) strb.setSecEn = regWe;
    if (regAddr == ADDR_W'(OFF_SECLR)) strb.clrSecEn = regWe;

    if (regAddr >= ADDR_W'(OFF_MAP) &&
        regAddr < ADDR_W'(OFF_MAP + 4 * PRIM_N) &&
        regAddr[1:0] == 2'b00) begin
      strb.wrMap = regWe;
      strb.chan  = mapOff[CHAN_W+1:2];
      strb.rdSel = RD_MAP;
    end
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [PRIM_N-1:1] primReq,
  input  logic [SEC_N-1:0]  secReq,
  output logic [DATA_W-1:0] regRdata,
  output logic              cpuIrq,
  output logic [PRIM_N-1:0] pendPrim,
  output logic [PRIM_N-1:0] enPrim,
  output logic [SEC_N-1:0]  secPend,
  output logic [SEC_N-1:0]  secEn
);
  logic [PRIM_N-1:0] clrMaskP, setMaskE, clrMaskE, rawPrim, activePrim;
  logic [SEC_N-1:0]  secClrMask, secSetMask, secEnClrMask, secActive;
  logic              cascadeLine;
  logic [IDX_W-1:0]  chanMap [PRIM_N];
  logic [CHAN_W-1:0] winChan;
  logic              winFound;
  logic [IDX_W-1:0]  prioIdx;

  // spread bank-wise write data onto the flat source vectors
  always_comb begin
    for (int i = 0; i < PRIM_N; i++) begin
      clrMaskP[i] = strb.clrPend[i / DATA_W] & regWdata[i % DATA_W];
      setMaskE[i] = strb.setEn[i / DATA_W]   & regWdata[i % DATA_W];
      clrMaskE[i] = strb.clrEn[i / DATA_W]   & regWdata[i % DATA_W];
    end
  end

  assign secClrMask   = strb.clrSec   ? regWdata[SEC_N-1:0] : '0;
  assign secSetMask   = strb.setSecEn ? regWdata[SEC_N-1:0] : '0;
  assign secEnClrMask = strb.clrSecEn ? regWdata[SEC_N-1:0] : '0;

  assign secActive   = secPend & secEn;
  assign cascadeLine = |secActive;
  assign rawPrim     = {primReq, cascadeLine};
  assign activePrim  = pendPrim & enPrim;
  assign cpuIrq      = |activePrim;

  always_ff @(posedge clk) begin
    if (rst) begin
      pendPrim <= '0;
      enPrim   <= '0;
      secPend  <= '0;
      secEn    <= '0;
    end else begin
      pendPrim <= (pendPrim & ~clrMaskP) | rawPrim;
      enPrim   <= (enPrim | setMaskE) & ~clrMaskE;
      secPend  <= (secPend & ~secClrMask) | secReq;
      secEn    <= (secEn | secSetMask) & ~secEnClrMask;
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < PRIM_N; c++) begin
      if (rst)
        chanMap[c] <= IDX_W'(c);
      else if (strb.wrMap && strb.chan == CHAN_W'(c))
        chanMap[c] <= regWdata[IDX_W-1:0];
    end
  end

  // downward scan leaves the lowest active channel
  always_comb begin
    winFound = 1'b0;
    winChan  = '0;
    for (int i = PRIM_N - 1; i >= 0; i--) begin
      if (activePrim[i]) begin
        winFound = 1'b1;
        winChan  = CHAN_W'(i);
      end
    end
  end

  assign prioIdx = winFound ? chanMap[winChan] : '0;

  always_comb begin
    regRdata = '0;
    case (strb.rdSel)
      RD_PEND: begin
        for (int i = 0; i < PRIM_N; i++)
          if (strb.bank == BANK_W'(i / DATA_W)) regRdata[i % DATA_W] = pendPrim[i];
      end
      RD_EN: begin
        for (int i = 0; i < PRIM_N; i++)
          if (strb.bank == BANK_W'(i / DATA_W)) regRdata[i % DATA_W] = enPrim[i];
      end
      RD_IDX:   regRdata = DATA_W'(prioIdx);
      RD_SSTAT: regRdata = DATA_W'(secActive);
      RD_MAP:   regRdata = DATA_W'(chanMap[strb.chan]);
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: rtl/intc_cascade.sv
module intc_cascade
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [PRIM_N-1:1] primReq,
  input  logic [SEC_N-1:0]  secReq,
  output logic              cpuIrq
);
  strobe_t           strb;
  logic [PRIM_N-1:0] pendPrim, enPrim;
  logic [SEC_N-1:0]  secPend, secEn;

  intc_ctrl u_ctrl (
    .regAddr (regAddr),
    .regWe   (regWe),
    .strb    (strb)
  );

  intc_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .regWdata (regWdata),
    .primReq  (primReq),
    .secReq   (secReq),
    .regRdata (regRdata),
    .cpuIrq   (cpuIrq),
    .pendPrim (pendPrim),
    .enPrim   (enPrim),
    .secPend  (secPend),
    .secEn    (secEn)
  );
endmodule

// File: rtl/intc_cascade_chk.sv
module intc_cascade_chk
  import intc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWe,
  input logic [DATA_W-1:0] regRdata,
  input logic [PRIM_N-1:1] primReq,
  input logic [SEC_N-1:0]  secReq,
  input logic              cpuIrq,
  input logic [PRIM_N-1:0] pendPrim,
  input logic [PRIM_N-1:0] enPrim,
  input logic [SEC_N-1:0]  secPend,
  input logic [SEC_N-1:0]  secEn
);
  assert_prim_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (primReq != '0) |=> ((pendPrim[PRIM_N-1:1] & $past(primReq)) == $past(primReq)));

  assert_sec_capture_R7: assert property (@(posedge clk) disable iff (rst)
    (secReq != '0) |=> ((secPend & $past(secReq)) == $past(secReq)));

  assert_cascade_line0_R9: assert property (@(posedge clk) disable iff (rst)
    ((secPend & secEn) != '0) |=> pendPrim[0]);

  assert_enable_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !regWe |=> ($stable(enPrim) && $stable(secEn)));

  assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (!regWe && cpuIrq) |=> cpuIrq);

  assert_idle_index_R6: assert property (@(posedge clk) disable iff (rst)
    (!cpuIrq && regAddr == ADDR_W'(OFF_PIDX)) |-> (regRdata == '0));
endmodule

bind intc_cascade intc_cascade_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .regAddr  (regAddr),
  .regWe    (regWe),
  .regRdata (regRdata),
  .primReq  (primReq),
  .secReq   (secReq),
  .cpuIrq   (cpuIrq),
  .pendPrim (pendPrim),
  .enPrim   (enPrim),
  .secPend  (secPend),
  .secEn    (secEn)
);

// File: tb/intc_cascade_test.sv
`timescale 1ns/1ps
module intc_cascade_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [39:1] primReq = '0;
  logic [31:0] secReq = '0;
  logic        cpuIrq;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  intc_cascade uut (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .primReq(primReq),
    .secReq(secReq), .cpuIrq(cpuIrq)
  );

  typedef struct packed {
    logic        chk;
    logic        we;
    logic [11:0] addr;
    logic [31:0] data;
    logic [39:0] prim;
    logic [31:0] sec;
    logic [31:0] exp;
    logic        irq;
    logic [3:0]  req;
  } vec_t;

  // each row drives one cycle; rdata/irq checked against state before that edge
  localparam int NV = 44;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,12'h040,32'h0,40'h0,32'h0,32'h0,1'b0,4'd1},           // R1 index idle
    '{1'b1,1'b0,12'h020,32'h0,40'h0,32'h0,32'h0,1'b0,4'd1},           // R1 enables off
    '{1'b1,1'b0,12'h010,32'h0,40'h2_0000_0020,32'h0,32'h0,1'b0,4'd2}, // R2 raise 5,33
    '{1'b1,1'b0,12'h010,32'h0,40'h0,32'h0,32'h20,1'b0,4'd2},          // R2 bank0 latched
    '{1'b1,1'b0,12'h014,32'h0,40'h0,32'h0,32'h2,1'b0,4'd2},           // R2 bank1 latched
    '{1'b0,1'b1,12'h020,32'h20,40'h0,32'h0,32'h0,1'b0,4'd4},          // R4 enable 5
    '{1'b1,1'b0,12'h020,32'h0,40'h0,32'h0,32'h20,1'b1,4'd4},          // R4 R5
    '{1'b1,1'b0,12'h040,32'h0,40'h0,32'h0,32'h5,1'b1,4'd6},           // R6 winner 5
    '{1'b0,1'b1,12'h024,32'h2,40'h0,32'h0,32'h0,1'b1,4'd4},           // R4 enable 33
    '{1'b1,1'b0,12'h024,32'h0,40'h0,32'h0,32'h2,1'b1,4'd4},           // R4
    '{1'b0,1'b1,12'h010,32'h0,40'h0,32'h0,32'h0,1'b1,4'd3},           // R3 zero clear
    '{1'b1,1'b0,12'h010,32'h0,40'h0,32'h0,32'h20,1'b1,4'd3},          // R3 unchanged
    '{1'b0,1'b1,12'h010,32'h20,40'h0,32'h0,32'h0,1'b1,4'd3},          // R3 clear 5
    '{1'b1,1'b0,12'h040,32'h0,40'h0,32'h0,32'h21,1'b1,4'd6},          // R6 winner 33
    '{1'b0,1'b1,12'h014,32'h2,40'h2_0000_0000,32'h0,32'h0,1'b1,4'd3}, // R3 clear vs req
    '{1'b1,1'b0,12'h014,32'h0,40'h0,32'h0,32'h2,1'b1,4'd3},           // R3 set wins
    '{1'b0,1'b1,12'h014,32'h2,40'h0,32'h0,32'h0,1'b1,4'd3},           // R3 clear 33
    '{1'b1,1'b0,12'h040,32'h0,40'h0,32'h0,32'h0,1'b0,4'd5},           // R5 R6 idle
    '{1'b0,1'b1,12'h034,32'h0,40'h0,32'h0,32'h0,1'b0,4'd4},           // R4 zero disable
    '{1'b1,1'b0,12'h024,32'h0,40'h0,32'h0,32'h2,1'b0,4'd4},           // R4 kept
    '{1'b0,1'b1,12'h034,32'h2,40'h0,32'h0,32'h0,1'b0,4'd4},           // R4 disable 33
    '{1'b1,1'b0,12'h024,32'h0,40'h0,32'h0,32'h0,1'b0,4'd4},           // R4
    '{1'b0,1'b1,12'h020,32'h1,40'h0,32'h8,32'h0,1'b0,4'd9},           // R9 enable line0, sec3
    '{1'b1,1'b0,12'h080,32'h0,40'h0,32'h0,32'h0,1'b0,4'd8},           // R8 masked
    '{1'b1,1'b0,12'h010,32'h0,40'h0,32'h0,32'h0,1'b0,4'd9},           // R9 no cascade
    '{1'b0,1'b1,12'h090,32'h8,40'h0,32'h0,32'h0,1'b0,4'd7},           // R7 enable sec3
    '{1'b1,1'b0,12'h080,32'h0,40'h0,32'h0,32'h8,1'b0,4'd8},           // R8
    '{1'b1,1'b0,12'h010,32'h0,40'h0,32'h0,32'h1,1'b1,4'd9},           // R9 line0 pending
    '{1'b1,1'b0,12'h040,32'h0,40'h0,32'h0,32'h0,1'b1,4'd6},           // R6 cascade only
    '{1'b0,1'b1,12'h088,32'h8,40'h0,32'h0,32'h0,1'b1,4'd7},           // R7 clear sec3
    '{1'b0,1'b1,12'h010,32'h1,40'h0,32'h0,32'h0,1'b1,4'd9},           // R9 ack line0
    '{1'b1,1'b0,12'h010,32'h0,40'h0,32'h0,32'h0,1'b0,4'd3},           // R3
    '{1'b1,1'b0,12'h080,32'h0,40'h0,32'h0,32'h0,1'b0,4'd8},           // R8
    '{1'b0,1'b1,12'h020,32'h500,40'h500,32'h0,32'h0,1'b0,4'd6},       // R6 raise 8,10
    '{1'b1,1'b0,12'h040,32'h0,40'h0,32'h0,32'h8,1'b1,4'd6},           // R6 winner 8
    '{1'b0,1'b1,12'h220,32'h2A,40'h0,32'h0,32'h0,1'b1,4'd10},         // R10 remap 8
    '{1'b1,1'b0,12'h220,32'h0,40'h0,32'h0,32'h2A,1'b1,4'd10},         // R10
    '{1'b1,1'b0,12'h040,32'h0,40'h0,32'h0,32'h2A,1'b1,4'd10},         // R10 mapped
    '{1'b0,1'b1,12'h010,32'h100,40'h0,32'h0,32'h0,1'b1,4'd3},         // R3 clear 8
    '{1'b1,1'b0,12'h040,32'h0,40'h0,32'h0,32'hA,1'b1,4'd6},           // R6 winner 10
    '{1'b1,1'b0,12'h228,32'h0,40'h0,32'h0,32'hA,1'b1,4'd1},           // R1 identity
    '{1'b1,1'b0,12'h21C,32'h0,40'h0,32'h0,32'h7,1'b1,4'd1},           // R1 identity
    '{1'b0,1'b1,12'h010,32'hFFFF_FFFF,40'h0,32'h0,32'h0,1'b1,4'd3},   // R3 clear all
    '{1'b1,1'b0,12'h010,32'h0,40'h0,32'h0,32'h0,1'b0,4'd5}            // R5 quiet
  };

  task automatic report(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic readChk(input logic [11:0] a, input logic [31:0] exp, input string req);
    regAddr = a;
    #1;
    report(regRdata == exp, req, regRdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      regWe = VECS[k].we; regAddr = VECS[k].addr; regWdata = VECS[k].data;
      primReq = VECS[k].prim[39:1]; secReq = VECS[k].sec;
      #1;
      if (VECS[k].chk)
        report(regRdata == VECS[k].exp, $sformatf("R%0d rdata row %0d", VECS[k].req, k),
               regRdata, VECS[k].exp);
      report(cpuIrq == VECS[k].irq, $sformatf("R%0d irq row %0d", VECS[k].req, k),
             {31'b0, cpuIrq}, {31'b0, VECS[k].irq});
    end
    @(negedge clk);
    regWe = 1'b0; primReq = '0; secReq = '0;

    // R4: bank 1 holds only eight enable bits
    doWrite(12'h024, 32'hFFFF_FFFF);
    readChk(12'h024, 32'h0000_00FF, "R4 bank1 width");

    // R7: secondary enable clear, R8 masked status
    doWrite(12'h090, 32'hFFFF_FFFF);
    doWrite(12'h098, 32'hFFFF_FFFE);
    secReq = 32'h8000_0001;
    @(negedge clk);
    secReq = '0;
    readChk(12'h080, 32'h0000_0001, "R7 R8 sec enable clear");

    // R7: clear loses against a request in the same cycle
    secReq = 32'h1;
    doWrite(12'h088, 32'h1);
    secReq = '0;
    readChk(12'h080, 32'h0000_0001, "R7 sec set wins");
    doWrite(12'h088, 32'hFFFF_FFFF);
    readChk(12'h080, 32'h0, "R7 sec cleared");

    // R1: reset restores quiet state and identity mapping
    doWrite(12'h220, 32'h5);
    readChk(12'h220, 32'h5, "R10 map write");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    readChk(12'h024, 32'h0, "R1 enables after reset");
    readChk(12'h014, 32'h0, "R1 pending after reset");
    readChk(12'h220, 32'h8, "R1 map identity after reset");
    readChk(12'h040, 32'h0, "R1 index after reset");
    report(cpuIrq == 1'b0, "R1 irq after reset", {31'b0, cpuIrq}, 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule